// File: doc/BRIEF.md
# Eligibility-Masked Minimum-Time Flow Scheduler

This block is the decision core of a weighted round-robin link scheduler. Every flow owns a priority register that holds the time at which it next deserves service. A smaller value means a more urgent flow. In each slot the block looks at all flows at once and masks out any flow whose queue is empty or whose stop bit is set. Among the flows that remain it picks the one with the smallest priority. That flow is granted, and its priority then advances by a per-flow service period. The period is the inverse of the flow's weight and is programmed through a small write port.

Selection uses a full comparison tree across all flows, rebuilt from the live masks every slot. There is no sorted structure to maintain, so any number of flows may be switched on or off in the same cycle. Broad backpressure that silences whole groups of flows costs nothing extra.

The grant leaves on a valid/ready stream. A grant stays on the outputs, unchanged, until the consumer takes it with `grant_ready` high. While a grant waits, no new selection is made and no priority moves. When the output slot is free or being emptied, the block makes a fresh selection that same cycle. The period write port is plain control and is not flow-controlled.

Top module: `wrr_sched`

## Requirements
- R1: After reset, `grant_valid` is 0 and every priority and period is zero. With all flows eligible and no period written, each grant goes to flow 0.
- R2: A flow takes part in selection only when its `flow_nonempty` bit is 1 and its `flow_stop` bit is 0. A set stop bit overrides a non-empty queue.
- R3: A selection grants the eligible flow whose priority is smallest.
- R4: When eligible flows tie on priority, the grant goes to the lowest flow index.
- R5: A selection with no eligible flow clears `grant_valid` and changes no priority.
- R6: On a grant, that flow's priority becomes its old priority plus its period. The sum is zero-extended and wraps modulo 2^KEY_W. The period used is the one held before any write in the same cycle.
- R7: While `grant_valid` is 1 and `grant_ready` is 0, `grant_valid` and `grant_flow` hold, and no priority changes.
- R8: A write with `per_wr_en` high sets the period of flow `per_wr_addr` to `per_wr_data` from the next cycle on.
- R9: The eligibility vectors may change arbitrarily between consecutive cycles. Each selection depends only on the vectors present in that cycle.
- R10: A selection is made on a clock edge whenever `grant_valid` is 0 or `grant_ready` is 1. The result appears on `grant_valid`/`grant_flow` right after that edge. The priority update applies to the next selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_nonempty | input | NUM_FLOWS | Per-flow queue-not-empty bits |
| flow_stop | input | NUM_FLOWS | Per-flow flow-control stop bits |
| per_wr_en | input | 1 | Period write strobe |
| per_wr_addr | input | IDX_W | Flow whose period is written |
| per_wr_data | input | PER_W | New service period |
| grant_valid | output | 1 | Grant present |
| grant_ready | input | 1 | Consumer accepts the grant |
| grant_flow | output | IDX_W | Index of the granted flow |

## Verification
The bench goes after equal priorities right after reset. A tree that favours the right-hand branch on equality would grant a high index instead of flow 0. It also masks the whole population, and stops flows that still have queued cells. A design that forgets to clear the valid flag, or ignores the stop bit, would keep issuing grants there. Holding `grant_ready` low checks that a stalled design neither changes the granted index nor silently advances a priority, either of which would show up later as a wrong choice. A long random phase then flips most eligibility bits every cycle and rewrites periods at random. Any slip in the update arithmetic or in which period is used shows up as a divergence from the reference selection.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD,
    ACT_IDLE,
    ACT_ISSUE
  } slot_act_e;
endpackage

// File: rtl/wrr_min_tree.sv
// Combinational minimum search over all flows; left subtree holds lower
// indices, so equal keys resolve toward the lower index.
module wrr_min_tree #(
  parameter int N  = 256,
  parameter int KW = 24,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]    elig,
  input  logic [N*KW-1:0] keys,
  output logic            found,
  output logic [IW-1:0]   win_idx,
  output logic [KW-1:0]   win_key
);
  localparam int LV = $clog2(N);
  localparam int P  = 1 << LV;

  for (genvar d = 0; d <= LV; d++) begin : g_lvl
    localparam int W = P >> d;
    logic [W-1:0]    v;
    logic [W*KW-1:0] k;
    logic [W*IW-1:0] x;
    if (d == 0) begin : g_leaf
      for (genvar j = 0; j < P; j++) begin : g_j
        if (j < N) begin : g_real
          assign v[j]           = elig[j];
          assign k[j*KW +: KW]  = keys[j*KW +: KW];
        end else begin : g_pad
          assign v[j]           = 1'b0;
          assign k[j*KW +: KW]  = '0;
        end
        assign x[j*IW +: IW] = IW'(j);
      end
    end else begin : g_comb
      for (genvar n = 0; n < W; n++) begin : g_node
        logic          lv, rv, take_l;
        logic [KW-1:0] kl, kr;
        logic [IW-1:0] xl, xr;
        assign lv = g_lvl[d-1].v[2*n];
        assign rv = g_lvl[d-1].v[2*n+1];
        assign kl = g_lvl[d-1].k[(2*n)*KW +: KW];
        assign kr = g_lvl[d-1].k[(2*n+1)*KW +: KW];
        assign xl = g_lvl[d-1].x[(2*n)*IW +: IW];
        assign xr = g_lvl[d-1].x[(2*n+1)*IW +: IW];
        assign take_l = lv && (!rv || (kl <= kr));
        assign v[n]          = lv | rv;
        assign k[n*KW +: KW] = take_l ? kl : kr;
        assign x[n*IW +: IW] = take_l ? xl : xr;
      end
    end
  end

  assign found   = g_lvl[LV].v[0];
  assign win_key = g_lvl[LV].k[KW-1:0];
  assign win_idx = g_lvl[LV].x[IW-1:0];

  // R2: the tree reports a winner exactly when some flow is eligible
  always_comb begin
    if (!$isunknown(elig)) begin
      p_found_r2: assert (found == (elig != '0));
    end
  end
endmodule

// File: rtl/wrr_period_table.sv
module wrr_period_table #(
  parameter int N  = 256,
  parameter int PW = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_addr,
  input  logic [PW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [PW-1:0] rd_data
);
  logic [PW-1:0] per_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) per_q[i] <= '0;
    end else if (wr_en && (int'(wr_addr) < N)) begin
      per_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = per_q[rd_idx];

  p_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_addr) < N)) |=> (per_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/wrr_prio_bank.sv
module wrr_prio_bank #(
  parameter int N  = 256,
  parameter int KW = 24,
  parameter int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_en,
  input  logic [IW-1:0]   upd_idx,
  input  logic [KW-1:0]   upd_base,
  input  logic [KW-1:0]   upd_inc,
  output logic [N*KW-1:0] prio_flat
);
  logic [KW-1:0] prio_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) prio_q[i] <= '0;
    end else if (upd_en) begin
      prio_q[upd_idx] <= upd_base + upd_inc;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    assign prio_flat[i*KW +: KW] = prio_q[i];
  end

  // R6: new value is the stored old value (not just the tree's copy) plus period
  p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (prio_q[$past(upd_idx)] == $past(prio_q[upd_idx]) + $past(upd_inc)));
endmodule

// File: rtl/wrr_sched.sv
module wrr_sched
  import wrr_pkg::*;
#(
  parameter int NUM_FLOWS = 256,
  parameter int KEY_W     = 24,
  parameter int PER_W     = 16,
  localparam int IDX_W    = $clog2(NUM_FLOWS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLOWS-1:0] flow_nonempty,
  input  logic [NUM_FLOWS-1:0] flow_stop,
  input  logic                 per_wr_en,
  input  logic [IDX_W-1:0]     per_wr_addr,
  input  logic [PER_W-1:0]     per_wr_data,
  output logic                 grant_valid,
  input  logic                 grant_ready,
  output logic [IDX_W-1:0]     grant_flow
);
  logic [NUM_FLOWS-1:0]       elig;
  logic [NUM_FLOWS*KEY_W-1:0] prio_flat;
  logic                       found;
  logic [IDX_W-1:0]           win_idx;
  logic [KEY_W-1:0]           win_key;
  logic [PER_W-1:0]           per_rd;
  logic                       slot_open, upd_en;
  slot_act_e                  act;

  assign elig      = flow_nonempty & ~flow_stop;
  assign slot_open = !grant_valid || grant_ready;

  wrr_min_tree #(.N(NUM_FLOWS), .KW(KEY_W), .IW(IDX_W)) i_tree (
    .elig    (elig),
    .keys    (prio_flat),
    .found   (found),
    .win_idx (win_idx),
    .win_key (win_key)
  );

  wrr_period_table #(.N(NUM_FLOWS), .PW(PER_W), .IW(IDX_W)) i_per (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (per_wr_en),
    .wr_addr (per_wr_addr),
    .wr_data (per_wr_data),
    .rd_idx  (win_idx),
    .rd_data (per_rd)
  );

  always_comb begin
    if (!slot_open)  act = ACT_HOLD;
    else if (found)  act = ACT_ISSUE;
    else             act = ACT_IDLE;
  end

  assign upd_en = (act == ACT_ISSUE);

  wrr_prio_bank #(.N(NUM_FLOWS), .KW(KEY_W), .IW(IDX_W)) i_prio (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (upd_en),
    .upd_idx   (win_idx),
    .upd_base  (win_key),
    .upd_inc   (KEY_W'(per_rd)),
    .prio_flat (prio_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_flow  <= '0;
    end else begin
      case (act)
        ACT_ISSUE: begin
          grant_valid <= 1'b1;
          grant_flow  <= win_idx;
        end
        ACT_IDLE: grant_valid <= 1'b0;
        default: ;
      endcase
    end
  end

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_open && (elig == '0)) |=> !grant_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_ready) |=> (grant_valid && $stable(grant_flow)));

  p_elig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_open && (elig != '0)) |=>
      (grant_valid && ((($past(elig) >> grant_flow) & NUM_FLOWS'(1)) != '0)));
endmodule

// File: tb/test_wrr_sched.sv
module test_wrr_sched;
  localparam int  N  = 256;
  localparam int  KW = 24;
  localparam int  PW = 16;
  localparam int  IW = 8;
  localparam time CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  flow_nonempty, flow_stop;
  logic          per_wr_en;
  logic [IW-1:0] per_wr_addr;
  logic [PW-1:0] per_wr_data;
  logic          grant_valid, grant_ready;
  logic [IW-1:0] grant_flow;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrr_sched #(.NUM_FLOWS(N), .KEY_W(KW), .PER_W(PW)) i_wrr_sched (
    .clk, .rst_n, .flow_nonempty, .flow_stop, .per_wr_en, .per_wr_addr,
    .per_wr_data, .grant_valid, .grant_ready, .grant_flow
  );

  int            checks = 0, errors = 0;
  logic [KW-1:0] mprio [N];
  logic [PW-1:0] mper  [N];
  logic          ev;
  int            ei;

  function automatic int find_min(input logic [N-1:0] e);
    int best = -1;
    for (int i = 0; i < N; i++)
      if (e[i] && (best < 0 || mprio[i] < mprio[best])) best = i;
    return best;
  endfunction

  task automatic check(input string req, input logic ok, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Predict the next edge from the driven inputs, then compare after it.
  task automatic cycle(input string req);
    logic [N-1:0] e = flow_nonempty & ~flow_stop;
    if (!ev || grant_ready) begin
      int w = find_min(e);
      if (w < 0) ev = 1'b0;
      else begin
        ev = 1'b1;
        ei = w;
        mprio[w] = mprio[w] + KW'(mper[w]);
      end
    end
    if (per_wr_en) mper[per_wr_addr] = per_wr_data;
    @(posedge clk);
    @(negedge clk);
    check(req, grant_valid === ev, "grant_valid", int'(grant_valid), int'(ev));
    if (ev) check(req, grant_flow === IW'(ei), "grant_flow", int'(grant_flow), ei);
  endtask

  task automatic rand_vec(output logic [N-1:0] v, input int pct);
    for (int i = 0; i < N; i++) v[i] = ($urandom % 100) < pct;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rst_n = 1'b0; flow_nonempty = '0; flow_stop = '0; grant_ready = 1'b1;
    per_wr_en = 1'b0; per_wr_addr = '0; per_wr_data = '0; ev = 1'b0; ei = 0;
    for (int i = 0; i < N; i++) begin mprio[i] = '0; mper[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", grant_valid === 1'b0, "reset grant_valid", int'(grant_valid), 0);
    rst_n = 1'b1;

    // R1: zero priorities and periods -> flow 0 every time
    flow_nonempty = '1;
    for (int i = 0; i < 4; i++) begin
      cycle("R1");
      check("R1", grant_flow === '0, "zero-state grant", int'(grant_flow), 0);
    end

    // R4: ties resolve to the lowest eligible index
    flow_stop = N'(5'h1f);
    for (int i = 0; i < 2; i++) begin
      cycle("R4");
      check("R4", grant_flow === IW'(5), "tie winner", int'(grant_flow), 5);
    end
    flow_stop = '0;

    // R8: program every period
    per_wr_en = 1'b1;
    for (int i = 0; i < N; i++) begin
      per_wr_addr = IW'(i);
      per_wr_data = PW'(1 + ($urandom % 400));
      cycle("R8");
    end
    per_wr_en = 1'b0;

    // R5: nothing eligible, then all stopped while non-empty
    flow_nonempty = '0;
    for (int i = 0; i < 3; i++) cycle("R5");
    flow_nonempty = '1; flow_stop = '1;
    for (int i = 0; i < 2; i++) cycle("R5");
    flow_stop = '0;

    // R2: highest index alone; stop overrides non-empty
    flow_nonempty = '0; flow_nonempty[N-1] = 1'b1;
    for (int i = 0; i < 3; i++) cycle("R2");
    flow_nonempty = '0; flow_nonempty[3] = 1'b1; flow_nonempty[7] = 1'b1;
    flow_stop[3] = 1'b1;
    cycle("R2");
    check("R2", grant_flow === IW'(7), "stopped flow skipped", int'(grant_flow), 7);
    flow_stop = '0;

    // R6: two flows with periods 3 and 5 alternate per their advancing times
    per_wr_en = 1'b1; per_wr_addr = IW'(10); per_wr_data = PW'(3); cycle("R6");
    per_wr_addr = IW'(11); per_wr_data = PW'(5); cycle("R6");
    per_wr_en = 1'b0;
    flow_nonempty = '0; flow_nonempty[10] = 1'b1; flow_nonempty[11] = 1'b1;
    for (int i = 0; i < 10; i++) cycle("R6");

    // R7: back-pressure holds the grant and freezes priorities
    flow_nonempty = '1; grant_ready = 1'b0;
    for (int i = 0; i < 4; i++) cycle("R7");
    rand_vec(flow_nonempty, 50);
    cycle("R7");
    grant_ready = 1'b1;
    cycle("R7");

    // R10: idle, then one flow appears; grant right after the next edge
    flow_nonempty = '0; cycle("R10");
    flow_nonempty[20] = 1'b1;
    cycle("R10");
    check("R10", grant_valid === 1'b1 && grant_flow === IW'(20),
          "one-edge latency", int'(grant_flow), 20);

    // R9/R3: rapid mass eligibility changes with random stalls and writes
    for (int c = 0; c < 4000; c++) begin
      int pick = $urandom % 3;
      rand_vec(flow_nonempty, (pick == 0) ? 5 : (pick == 1) ? 50 : 95);
      rand_vec(flow_stop, 30);
      grant_ready = ($urandom % 100) < 80;
      per_wr_en   = ($urandom % 100) < 5;
      per_wr_addr = IW'($urandom % N);
      per_wr_data = PW'(1 + ($urandom % 400));
      cycle((c % 2 == 0) ? "R9" : "R3");
    end
    per_wr_en = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule